// File: doc/BRIEF.md
# Clocked Controller for an 8K x 8 Asynchronous Static RAM

This block lets clocked logic read and write an external asynchronous static RAM holding 8192 bytes. The client side presents one request at a time (direction, 13-bit address, 8-bit write data) with a valid/ready handshake. The memory side has registered address, strobe and data-bus lines. These are an active-low chip enable, an active-high chip enable, an active-low output enable, an active-low write enable, and a shared data bus. The bus is split into an outgoing value, a driver enable and an incoming value.

The memory's analogue timing is met by counting system clocks. Each minimum (access time, write pulse width, data setup before the end of a write, address setup before the end of a write, chip-enable time before the end of a write, bus release after write enable falls, whole write cycle) is a parameter in picoseconds. It is turned into a clock count by rounding up against the clock period. A write is closed by raising write enable while both chip enables stay asserted. The data drivers switch on only after the memory's release window has passed. Read data comes back with a one-cycle valid strobe.

Top module: `sram_async_ctrl`

## Requirements
- R1: Out of reset and whenever `req_ready` is high, the memory is deselected and quiet: `sram_ce1_n`=1, `sram_ce2`=0, `sram_we_n`=1, `sram_oe_n`=1, `sram_dq_oe`=0.
- R2: A request is taken at a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the next cycle until the access is complete. `sram_addr` and the driven write data do not change during the access, whatever the request inputs do.
- R3: A read (`req_write`=0) keeps both chip enables asserted, `sram_oe_n`=0 and `sram_we_n`=1 for AA cycles, where AA = ceil(T_AA_PS/CLK_PS), at least 1. `sram_dq_in` is sampled at the edge closing the last of those cycles. `rd_valid` is 1 for exactly one cycle after that edge. With the defaults, it is seen on the second falling edge after the accepting edge.
- R4: `rd_data` equals the byte most recently written to the same address. It is 0 for an address that has never been written, against a zero-initialised memory.
- R5: A write (`req_write`=1) runs four phases. First, 1 cycle with the chip enables on and `sram_we_n`=1. Second, HZ cycles with `sram_we_n`=0 and drivers off, where HZ = ceil(T_HZWE_PS/CLK_PS). Third, DRV cycles with `sram_we_n`=0 and drivers on, where DRV is the largest of SD, PWE-HZ, max(AW,SCE)-1-HZ and 1. Last, END cycles with `sram_we_n`=1, enables on and drivers on, where END = max(1, WC-1-HZ-DRV). With the defaults, `req_ready` returns 4 cycles after acceptance.
- R6: Each write meets its minimums. Write enable is low for at least T_PWE_PS. The data is driven and stable for at least T_SD_PS before write enable rises. The address is stable with the chip selected for at least T_AW_PS before write enable rises.
- R7: `sram_oe_n` is never 0 while `sram_we_n` is 0 or `sram_dq_oe` is 1. The controller and the memory never drive the bus together.
- R8: Every write ends with `sram_we_n` rising while `sram_ce1_n`=0 and `sram_ce2`=1.
- R9: `rd_valid` pulses only at the end of a read. A write produces no `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Byte address |
| req_wdata | input | 8 | Write data |
| rd_valid | output | 1 | One-cycle strobe for `rd_data` |
| rd_data | output | 8 | Read result |
| sram_addr | output | 13 | Memory address lines |
| sram_ce1_n | output | 1 | Active-low chip enable |
| sram_ce2 | output | 1 | Active-high chip enable |
| sram_we_n | output | 1 | Active-low write enable |
| sram_oe_n | output | 1 | Active-low output enable |
| sram_dq_out | output | 8 | Value driven onto the data bus |
| sram_dq_oe | output | 1 | Data bus driver enable |
| sram_dq_in | input | 8 | Value seen on the data bus |

## Verification
Every pin is registered, so each result is counted in falling edges after the accepting rising edge. With the defaults, read data and its strobe are due on the second falling edge (AA+1). The return of `req_ready` after a write is due on the fifth (phase total + 1). The bench computes both counts from the timing parameters and compares the measured edge count to them exactly. A behavioural memory model samples the pins on every falling edge and counts how long write enable, data and address were held. When write enable rises, it stores the byte and checks those counts in picoseconds against the minimums. A scoreboard checks each returned byte against the last byte written to that address.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_ACCESS,
        S_WR_ARM,
        S_WR_RELEASE,
        S_WR_DRIVE,
        S_WR_CLOSE
    } phase_e;

    typedef struct packed {
        logic ce1_n;
        logic ce2;
        logic we_n;
        logic oe_n;
        logic drv;
    } pins_t;

    // Round a time up to whole clocks, never below one cycle.
    function automatic int clocks_for(input int t_ps, input int clk_ps);
        int c;
        c = (t_ps + clk_ps - 1) / clk_ps;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Memory-side strobe levels held during each phase.
    function automatic pins_t pins_for(input phase_e p);
        pins_t v;
        v = '{ce1_n: 1'b1, ce2: 1'b0, we_n: 1'b1, oe_n: 1'b1, drv: 1'b0};
        unique case (p)
            S_IDLE:       v = '{ce1_n: 1'b1, ce2: 1'b0, we_n: 1'b1, oe_n: 1'b1, drv: 1'b0};
            S_RD_ACCESS:  v = '{ce1_n: 1'b0, ce2: 1'b1, we_n: 1'b1, oe_n: 1'b0, drv: 1'b0};
            S_WR_ARM:     v = '{ce1_n: 1'b0, ce2: 1'b1, we_n: 1'b1, oe_n: 1'b1, drv: 1'b0};
            S_WR_RELEASE: v = '{ce1_n: 1'b0, ce2: 1'b1, we_n: 1'b0, oe_n: 1'b1, drv: 1'b0};
            S_WR_DRIVE:   v = '{ce1_n: 1'b0, ce2: 1'b1, we_n: 1'b0, oe_n: 1'b1, drv: 1'b1};
            S_WR_CLOSE:   v = '{ce1_n: 1'b0, ce2: 1'b1, we_n: 1'b1, oe_n: 1'b1, drv: 1'b1};
            default:      v = '{ce1_n: 1'b1, ce2: 1'b0, we_n: 1'b1, oe_n: 1'b1, drv: 1'b0};
        endcase
        return v;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == '0);

    // A freshly loaded count drains by exactly one per cycle.
    a_r5_timer_drains: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              valid;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d       = cap_q;
        cap_d.valid = sample;
        if (sample) cap_d.data = bus_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign rd_data  = cap_q.data;
    assign rd_valid = cap_q.valid;

    a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !$past(rd_valid));

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W     = 13,
    parameter int DATA_W     = 8,
    parameter int CLK_PS     = 10000,
    parameter int T_AA_PS    = 10000,
    parameter int T_WC_PS    = 10000,
    parameter int T_SCE_PS   = 8000,
    parameter int T_AW_PS    = 7000,
    parameter int T_PWE_PS   = 7000,
    parameter int T_SD_PS    = 6000,
    parameter int T_HZWE_PS  = 6000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_ce1_n,
    output logic              sram_ce2,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_in
);

    // Phase lengths in clocks, derived from the analogue minimums.
    localparam int ARM_CYC = 1;
    localparam int AA_CYC  = clocks_for(T_AA_PS, CLK_PS);
    localparam int HZ_CYC  = clocks_for(T_HZWE_PS, CLK_PS);
    localparam int SD_CYC  = clocks_for(T_SD_PS, CLK_PS);
    localparam int PWE_CYC = clocks_for(T_PWE_PS, CLK_PS);
    localparam int AW_CYC  = clocks_for(T_AW_PS, CLK_PS);
    localparam int SCE_CYC = clocks_for(T_SCE_PS, CLK_PS);
    localparam int WC_CYC  = clocks_for(T_WC_PS, CLK_PS);
    localparam int DRV_CYC = max_of(max_of(SD_CYC, PWE_CYC - HZ_CYC),
                                    max_of(max_of(AW_CYC, SCE_CYC) - ARM_CYC - HZ_CYC, 1));
    localparam int END_CYC = max_of(1, WC_CYC - ARM_CYC - HZ_CYC - DRV_CYC);
    localparam int MAX_CYC = max_of(max_of(HZ_CYC, DRV_CYC), max_of(END_CYC, AA_CYC));
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        phase_e            phase;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        pins_t             pins;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  tmr_load;
    cnt_t  tmr_val;
    logic  tmr_done;
    logic  rd_sample;

    always_comb begin
        st_d      = st_q;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        rd_sample = 1'b0;
        unique case (st_q.phase)
            S_IDLE: begin
                if (req_valid) begin
                    st_d.addr = req_addr;
                    tmr_load  = 1'b1;
                    if (req_write) begin
                        st_d.wdata = req_wdata;
                        st_d.phase = S_WR_ARM;
                        tmr_val    = cnt_t'(ARM_CYC - 1);
                    end else begin
                        st_d.phase = S_RD_ACCESS;
                        tmr_val    = cnt_t'(AA_CYC - 1);
                    end
                end
            end
            S_RD_ACCESS: begin
                if (tmr_done) begin
                    rd_sample  = 1'b1;
                    st_d.phase = S_IDLE;
                end
            end
            S_WR_ARM: begin
                if (tmr_done) begin
                    st_d.phase = S_WR_RELEASE;
                    tmr_load   = 1'b1;
                    tmr_val    = cnt_t'(HZ_CYC - 1);
                end
            end
            S_WR_RELEASE: begin
                if (tmr_done) begin
                    st_d.phase = S_WR_DRIVE;
                    tmr_load   = 1'b1;
                    tmr_val    = cnt_t'(DRV_CYC - 1);
                end
            end
            S_WR_DRIVE: begin
                if (tmr_done) begin
                    st_d.phase = S_WR_CLOSE;
                    tmr_load   = 1'b1;
                    tmr_val    = cnt_t'(END_CYC - 1);
                end
            end
            S_WR_CLOSE: begin
                if (tmr_done) st_d.phase = S_IDLE;
            end
            default: st_d.phase = S_IDLE;
        endcase
        st_d.pins = pins_for(st_d.phase);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= S_IDLE;
            st_q.addr  <= '0;
            st_q.wdata <= '0;
            st_q.pins  <= pins_for(S_IDLE);
        end else begin
            st_q <= st_d;
        end
    end

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    sram_rd_capture #(.DATA_W(DATA_W)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample   (rd_sample),
        .bus_in   (sram_dq_in),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    assign req_ready   = (st_q.phase == S_IDLE);
    assign sram_addr   = st_q.addr;
    assign sram_dq_out = st_q.wdata;
    assign sram_ce1_n  = st_q.pins.ce1_n;
    assign sram_ce2    = st_q.pins.ce2;
    assign sram_we_n   = st_q.pins.we_n;
    assign sram_oe_n   = st_q.pins.oe_n;
    assign sram_dq_oe  = st_q.pins.drv;

    // Length of the current write-enable low pulse, for the width check.
    logic [CNT_W:0] we_lo_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          we_lo_q <= '0;
        else if (!sram_we_n) we_lo_q <= we_lo_q + 1'b1;
        else                 we_lo_q <= '0;
    end

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (sram_ce1_n && !sram_ce2 && sram_we_n && sram_oe_n && !sram_dq_oe));

    a_r2_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && $past(!req_ready)) |-> ($stable(sram_addr) && $stable(sram_dq_out)));

    a_r3_read_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_oe_n |-> (!sram_ce1_n && sram_ce2 && sram_we_n));

    a_r5_drive_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_dq_oe) |-> (!sram_we_n && $past(!sram_we_n)));

    a_r6_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> (we_lo_q >= (CNT_W+1)'(PWE_CYC)));

    a_r7_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_oe_n |-> !sram_dq_oe);

    a_r8_end_selected: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> (!sram_ce1_n && sram_ce2));

    a_r9_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(!sram_oe_n));

endmodule

// File: tb/sram_async_ctrl_tb.sv
module sram_async_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int CLK_PS     = 10000;
    localparam int T_AA_PS    = 10000;
    localparam int T_WC_PS    = 10000;
    localparam int T_SCE_PS   = 8000;
    localparam int T_AW_PS    = 7000;
    localparam int T_PWE_PS   = 7000;
    localparam int T_SD_PS    = 6000;
    localparam int T_HZWE_PS  = 6000;
    localparam int DEPTH      = 8192;

    function automatic int cyc(input int ps);
        int c;
        c = (ps + CLK_PS - 1) / CLK_PS;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Expected counts per R3 and R5.
    function automatic int read_edges();
        return cyc(T_AA_PS) + 1;
    endfunction

    function automatic int write_edges();
        int hz, drv, fin;
        hz  = cyc(T_HZWE_PS);
        drv = mx(mx(cyc(T_SD_PS), cyc(T_PWE_PS) - hz),
                 mx(mx(cyc(T_AW_PS), cyc(T_SCE_PS)) - 1 - hz, 1));
        fin = mx(1, cyc(T_WC_PS) - 1 - hz - drv);
        return 1 + hz + drv + fin + 1;
    endfunction

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [12:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic [12:0] sram_addr;
    logic        sram_ce1_n, sram_ce2, sram_we_n, sram_oe_n, sram_dq_oe;
    logic [7:0]  sram_dq_out;
    logic [7:0]  sram_dq_in;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_async_ctrl #(
        .CLK_PS(CLK_PS), .T_AA_PS(T_AA_PS), .T_WC_PS(T_WC_PS), .T_SCE_PS(T_SCE_PS),
        .T_AW_PS(T_AW_PS), .T_PWE_PS(T_PWE_PS), .T_SD_PS(T_SD_PS), .T_HZWE_PS(T_HZWE_PS)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .sram_addr(sram_addr),
        .sram_ce1_n(sram_ce1_n), .sram_ce2(sram_ce2), .sram_we_n(sram_we_n),
        .sram_oe_n(sram_oe_n), .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe),
        .sram_dq_in(sram_dq_in)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Behavioural memory and scoreboard.
    logic [7:0] mem [DEPTH];
    logic [7:0] sb  [DEPTH];
    logic       sel, mem_drive;
    assign sel        = !sram_ce1_n && sram_ce2;
    assign mem_drive  = sel && !sram_oe_n && sram_we_n;
    assign sram_dq_in = mem_drive ? mem[sram_addr] : 8'h00;

    bit         mon_we_lo = 1'b0;
    int         mon_we_cnt = 0, mon_dat_cnt = 0, mon_adr_cnt = 0;
    logic [7:0] mon_dat = '0;
    logic [12:0] mon_adr = '0;
    int         rd_pulses = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_valid) rd_pulses++;
            if (mon_we_lo && sram_we_n) begin
                check(mon_we_cnt * CLK_PS >= T_PWE_PS, "R6 write pulse width ps", mon_we_cnt * CLK_PS, T_PWE_PS);
                check(mon_dat_cnt * CLK_PS >= T_SD_PS, "R6 data setup ps", mon_dat_cnt * CLK_PS, T_SD_PS);
                check(mon_adr_cnt * CLK_PS >= T_AW_PS, "R6 address setup ps", mon_adr_cnt * CLK_PS, T_AW_PS);
                check(sel, "R8 enables held at write end", int'(sel), 1);
                mem[mon_adr] = mon_dat;
            end
            check(!(mem_drive && sram_dq_oe), "R7 bus contention", int'(mem_drive && sram_dq_oe), 0);
            check(!(!sram_oe_n && !sram_we_n), "R7 oe low during write", int'(sram_oe_n), 1);
            if (req_ready)
                check(sram_ce1_n && !sram_ce2 && sram_we_n && sram_oe_n && !sram_dq_oe,
                      "R1 idle pins", {27'd0, sram_ce1_n, sram_ce2, sram_we_n, sram_oe_n, sram_dq_oe}, 5'b10110);
            mon_we_lo  = sel && !sram_we_n;
            mon_we_cnt = mon_we_lo ? mon_we_cnt + 1 : 0;
            if (sel && sram_dq_oe && mon_dat_cnt != 0 && sram_dq_out == mon_dat) mon_dat_cnt++;
            else mon_dat_cnt = (sel && sram_dq_oe) ? 1 : 0;
            if (sel && mon_adr_cnt != 0 && sram_addr == mon_adr) mon_adr_cnt++;
            else mon_adr_cnt = sel ? 1 : 0;
            mon_dat = sram_dq_out;
            mon_adr = sram_addr;
        end
    end

    task automatic do_write(input logic [12:0] a, input logic [7:0] d);
        int n;
        int p0;
        logic [12:0] held;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        p0 = rd_pulses;
        @(negedge clk);
        req_valid = 1'b0; req_addr = 13'($urandom); req_wdata = 8'($urandom);
        check(!req_ready, "R2 ready low after accept", int'(req_ready), 0);
        held = sram_addr;
        n = 1;
        while (!req_ready && n < 50) begin
            @(negedge clk);
            n++;
            if (!req_ready) check(sram_addr == held, "R2 address held", int'(sram_addr), int'(held));
        end
        check(n == write_edges(), "R5 write length in edges", n, write_edges());
        check(rd_pulses == p0, "R9 no strobe on write", rd_pulses - p0, 0);
        sb[a] = d;
    endtask

    task automatic do_read(input logic [12:0] a);
        int n;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_wdata = 8'($urandom);
        @(negedge clk);
        req_valid = 1'b0; req_addr = 13'($urandom);
        n = 1;
        while (!rd_valid && n < 50) begin
            @(negedge clk);
            n++;
        end
        check(n == read_edges(), "R3 read latency in edges", n, read_edges());
        check(rd_data == sb[a], "R4 read data", int'(rd_data), int'(sb[a]));
        @(negedge clk);
        check(!rd_valid, "R3 strobe one cycle", int'(rd_valid), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int seed_v;
        seed_v = int'($urandom(32'd7715));
        for (int i = 0; i < DEPTH; i++) begin
            mem[i] = 8'h00;
            sb[i]  = 8'h00;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet state straight out of reset
        check(req_ready && sram_ce1_n && !sram_ce2 && sram_we_n && sram_oe_n && !sram_dq_oe && !rd_valid,
              "R1 reset state", int'(req_ready), 1);

        // Directed corners: lowest and highest address, all-zero and all-one data.
        do_read(13'd5);
        do_write(13'd0, 8'hA5);
        do_write(13'd8191, 8'hFF);
        do_write(13'd1, 8'h00);
        do_read(13'd0);
        do_read(13'd8191);
        do_read(13'd1);
        do_write(13'd0, 8'h3C);
        do_read(13'd0);
        do_write(13'd4096, 8'h81);
        do_write(13'd4096, 8'h7E);
        do_read(13'd4096);

        // Random mix, biased to a small window so reads hit earlier writes.
        for (int k = 0; k < 400; k++) begin
            logic [12:0] a;
            a = ($urandom % 4 == 0) ? 13'($urandom % DEPTH) : 13'($urandom % 16);
            if ($urandom % 2 == 0) do_write(a, 8'($urandom));
            else                   do_read(a);
        end
        repeat (4) @(negedge clk);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule